// File: doc/BRIEF.md
# I/O Rail Deep Power-Down Sequencer

This block controls the deep power-down state of a set of I/O rails. The rails are split into banks, 30 per bank by default with two banks, giving 60 rails. Each bank has a request register and a status register. The request register holds a rail-select field in its low bits and a two-bit command in its top two bits. Software writes a select mask and a command into a bank's request register. Once the global sample enable is set, the bank drives the power-down controls of the selected rails. It then waits a programmed number of bus-clock cycles before it updates the status bits of those rails.

The dwell count is set in a timing register. Software loads it with enough cycles to cover at least 200 ns of the bus clock, for example 20 cycles at 100 MHz. When the status has been updated, the command field of the request register goes back to idle and the select mask stays as written. Software can poll the status register until the change shows up. A request completes in at most 2^16 cycles, which is far below any software timeout.

Top module: `rail_dpd_seq`

## Requirements
- R1: After reset every rail is powered: all power-down controls are 0 and all status bits are 0. The timing register, the sample enable and both request registers read 0.
- R2: The register word map is: address 0 holds the sample enable in bit 0, address 1 holds the dwell count in bits 15:0, addresses 2 and 3 are the request and status of bank 0, and addresses 4 and 5 are the request and status of bank 1. Any other address reads 0. Bank b bit i maps to rail index 30·b+i on the rail outputs.
- R3: Bits 31:30 of a request register hold the command. Value 2 puts the selected rails into power-down (control and status go to 1). Value 1 returns them to powered (control and status go to 0). Value 0 causes no action.
- R4: While the sample enable is 0, no request is started. A pending request is held and starts on the first edge after the sample enable becomes 1.
- R5: The power-down controls change on the first clock edge after the request is written. The status bits follow exactly max(dwell,1) cycles later.
- R6: A dwell count of 0 behaves as a count of 1.
- R7: When the status is updated, the command field returns to 0 and the select bits keep their value.
- R8: Only the selected rails change. The control and status bits of unselected rails keep their values.
- R9: The banks run independently, and both may be in their dwell at the same time.
- R10: A write to a bank's request register while that bank is in its dwell is ignored.
- R11: Command value 3 is reserved and causes no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr |
| rail_pd | output | 60 | Per-rail power-down control, 1 = power-down |
| rail_stat | output | 60 | Per-rail status, 1 = in power-down |

## Verification
A behavioural model in the bench tracks each bank's request, its remaining dwell and its rail state. The model is compared with both rail vectors and the read data on every clock. The stimulus uses enter and leave commands on overlapping masks, which separates rails that were selected from rails that were not. It uses the reserved command and the idle command with a non-zero mask, which shows whether the command is decoded or only the mask is. It uses dwell counts of 0, 5 and 8 to expose off-by-one errors in the count. Further cases cover requests written while sampling is off, overlapping requests to both banks, and a write to a bank in its dwell; these confirm that a request is held, that the banks run separately, and that a write during the dwell is dropped.

// File: rtl/rail_dpd_pkg.sv
package rail_dpd_pkg;
   // command field values (top two bits of a request word)
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_LEAVE = 2'd1,
      CMD_ENTER = 2'd2,
      CMD_RSVD  = 2'd3
   } dpd_cmd_e;

   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_DWELL = 1'b1
   } eng_state_e;

   localparam int unsigned ADDR_SAMPLE = 0;
   localparam int unsigned ADDR_DWELL  = 1;
   localparam int unsigned ADDR_BANK0  = 2;   // request at 2+2b, status at 3+2b
endpackage

// File: rtl/rail_dpd_cfg.sv
module rail_dpd_cfg #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic               sample_en,
   output logic [TIMER_W-1:0] dwell
);
   import rail_dpd_pkg::*;

   initial begin : p_param_chk
      assert (TIMER_W <= DATA_W) else $error("dwell field wider than data word");
   end

   logic               samp_q;
   logic [TIMER_W-1:0] dwell_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q  <= 1'b0;
         dwell_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(ADDR_SAMPLE)) samp_q  <= reg_wdata[0];
         if (reg_addr == ADDR_W'(ADDR_DWELL))  dwell_q <= reg_wdata[TIMER_W-1:0];
      end
   end

   assign sample_en = samp_q;
   assign dwell     = dwell_q;

   // R2: configuration only moves on a write
   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ($stable(dwell_q) && $stable(samp_q)));
endmodule

// File: rtl/rail_dpd_bank.sv
module rail_dpd_bank #(
   parameter int unsigned RAILS   = 30,
   parameter int unsigned TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_wr,
   input  logic [RAILS-1:0]   wr_sel,
   input  logic [1:0]         wr_cmd,
   input  logic               sample_en,
   input  logic [TIMER_W-1:0] dwell,
   output logic [RAILS-1:0]   req_sel,
   output logic [1:0]         req_cmd,
   output logic [RAILS-1:0]   stat,
   output logic [RAILS-1:0]   pd
);
   import rail_dpd_pkg::*;

   eng_state_e         st_q;
   logic [RAILS-1:0]   sel_q, lat_q, stat_q, pd_q;
   logic [1:0]         cmd_q;
   logic               enter_q;
   logic [TIMER_W-1:0] cnt_q;
   logic               go;
   logic               go_enter;
   logic [TIMER_W-1:0] load_val;

   always_comb begin
      go       = sample_en && ((cmd_q == CMD_ENTER) || (cmd_q == CMD_LEAVE));
      go_enter = (cmd_q == CMD_ENTER);
      load_val = (dwell == '0) ? TIMER_W'(1) : dwell;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ENG_IDLE;
         sel_q   <= '0;
         cmd_q   <= CMD_NONE;
         lat_q   <= '0;
         enter_q <= 1'b0;
         cnt_q   <= '0;
         stat_q  <= '0;
         pd_q    <= '0;
      end else begin
         unique case (st_q)
            ENG_IDLE: begin
               if (go) begin
                  lat_q   <= sel_q;
                  enter_q <= go_enter;
                  pd_q    <= go_enter ? (pd_q | sel_q) : (pd_q & ~sel_q);
                  cnt_q   <= load_val;
                  st_q    <= ENG_DWELL;
               end
               if (req_wr) begin
                  sel_q <= wr_sel;
                  cmd_q <= wr_cmd;
               end
            end
            ENG_DWELL: begin
               if (cnt_q == TIMER_W'(1)) begin
                  stat_q <= enter_q ? (stat_q | lat_q) : (stat_q & ~lat_q);
                  cmd_q  <= CMD_NONE;
                  cnt_q  <= '0;
                  st_q   <= ENG_IDLE;
               end else begin
                  cnt_q <= cnt_q - TIMER_W'(1);
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign req_sel = sel_q;
   assign req_cmd = cmd_q;
   assign stat    = stat_q;
   assign pd      = pd_q;

   // R5: status never moves while the engine is idle
   assert_stat_only_after_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_IDLE) |=> $stable(stat_q));
   // R7: last dwell cycle leaves the command idle and keeps the mask
   assert_cmd_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_DWELL && cnt_q == TIMER_W'(1)) |=> (cmd_q == CMD_NONE && $stable(sel_q)));
   // R4: nothing starts with sampling off
   assert_hold_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_en && st_q == ENG_IDLE) |=> (st_q == ENG_IDLE && $stable(pd_q)));
   // R8: control and status agree whenever no request is in flight
   assert_ctrl_stat_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_IDLE) |-> (pd_q == stat_q));
   // R6: a running dwell never holds a zero count
   assert_dwell_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_DWELL) |-> (cnt_q != '0));
   // R10: the request word stays put during the dwell except for the clear
   assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_DWELL && cnt_q != TIMER_W'(1)) |=> ($stable(sel_q) && $stable(cmd_q)));
endmodule

// File: rtl/rail_dpd_seq.sv
module rail_dpd_seq #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned RAILS     = 30,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TIMER_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic [NUM_BANKS*RAILS-1:0] rail_pd,
   output logic [NUM_BANKS*RAILS-1:0] rail_stat
);
   import rail_dpd_pkg::*;

   localparam int unsigned CMD_LSB = DATA_W - 2;
   localparam int unsigned PAD_W   = DATA_W - RAILS;

   initial begin : p_param_chk
      assert (RAILS + 2 <= DATA_W) else $error("rail mask overlaps command field");
      assert (ADDR_BANK0 + 2*NUM_BANKS <= (1 << ADDR_W)) else $error("address space too small");
      assert (NUM_BANKS >= 1) else $error("need at least one bank");
   end

   logic               sample_en;
   logic [TIMER_W-1:0] dwell;
   logic [RAILS-1:0]   b_sel  [NUM_BANKS];
   logic [1:0]         b_cmd  [NUM_BANKS];
   logic [RAILS-1:0]   b_stat [NUM_BANKS];

   rail_dpd_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMER_W(TIMER_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .sample_en (sample_en),
      .dwell     (dwell)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_BANK0 + 2*b));

      rail_dpd_bank #(.RAILS(RAILS), .TIMER_W(TIMER_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_wr    (bank_wr),
         .wr_sel    (reg_wdata[RAILS-1:0]),
         .wr_cmd    (reg_wdata[CMD_LSB +: 2]),
         .sample_en (sample_en),
         .dwell     (dwell),
         .req_sel   (b_sel[b]),
         .req_cmd   (b_cmd[b]),
         .stat      (b_stat[b]),
         .pd        (rail_pd[b*RAILS +: RAILS])
      );
      assign rail_stat[b*RAILS +: RAILS] = b_stat[b];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_SAMPLE))
         reg_rdata = {{(DATA_W-1){1'b0}}, sample_en};
      else if (reg_addr == ADDR_W'(ADDR_DWELL))
         reg_rdata = DATA_W'(dwell);
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (reg_addr == ADDR_W'(ADDR_BANK0 + 2*b)) begin
            reg_rdata = '0;
            reg_rdata[RAILS-1:0]   = b_sel[b];
            reg_rdata[CMD_LSB +: 2] = b_cmd[b];
         end
         if (reg_addr == ADDR_W'(ADDR_BANK0 + 2*b + 1))
            reg_rdata = {{PAD_W{1'b0}}, b_stat[b]};
      end
   end
endmodule

// File: tb/rail_dpd_seq_tb.sv
module rail_dpd_seq_tb_top;
   localparam int NB = 2;
   localparam int NR = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [59:0] rail_pd, rail_stat;

   int compared = 0;
   int mismatched = 0;
   string cur_req = "R1";
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   rail_dpd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rail_pd(rail_pd), .rail_stat(rail_stat)
   );

   // behavioural reference
   bit          m_samp;
   int          m_dwell;
   bit [29:0]   m_sel [NB];
   int          m_cmd [NB];
   bit [29:0]   m_pd [NB], m_st [NB], m_lat [NB];
   bit          m_ent [NB];
   int          m_left [NB];

   function automatic bit [31:0] m_read(int a);
      if (a == 0) return {31'b0, m_samp};
      if (a == 1) return 32'(m_dwell);
      for (int b = 0; b < NB; b++) begin
         if (a == 2 + 2*b) return {m_cmd[b][1:0], m_sel[b]};
         if (a == 3 + 2*b) return {2'b0, m_st[b]};
      end
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_samp = 0; m_dwell = 0;
         for (int b = 0; b < NB; b++) begin
            m_sel[b] = '0; m_cmd[b] = 0; m_pd[b] = '0; m_st[b] = '0;
            m_lat[b] = '0; m_ent[b] = 0; m_left[b] = 0;
         end
      end else begin
         for (int b = 0; b < NB; b++) begin
            bit was_busy;
            was_busy = (m_left[b] != 0);
            if (was_busy) begin
               if (m_left[b] == 1) begin
                  if (m_ent[b]) m_st[b] = m_st[b] | m_lat[b];
                  else          m_st[b] = m_st[b] & ~m_lat[b];
                  m_cmd[b] = 0;
                  m_left[b] = 0;
               end else m_left[b]--;
            end else if (m_samp && (m_cmd[b] == 1 || m_cmd[b] == 2)) begin
               m_lat[b] = m_sel[b];
               m_ent[b] = (m_cmd[b] == 2);
               if (m_ent[b]) m_pd[b] = m_pd[b] | m_sel[b];
               else          m_pd[b] = m_pd[b] & ~m_sel[b];
               m_left[b] = (m_dwell == 0) ? 1 : m_dwell;
            end
            if (reg_wr && !was_busy && int'(reg_addr) == 2 + 2*b) begin
               m_sel[b] = reg_wdata[29:0];
               m_cmd[b] = int'(reg_wdata[31:30]);
            end
         end
         if (reg_wr && reg_addr == 3'd0) m_samp = reg_wdata[0];
         if (reg_wr && reg_addr == 3'd1) m_dwell = int'(reg_wdata[15:0]);
      end
   end

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("rail_pd",   {4'b0, rail_pd},   {4'b0, m_pd[1], m_pd[0]});
         chk("rail_stat", {4'b0, rail_stat}, {4'b0, m_st[1], m_st[0]});
         chk("rdata",     {32'b0, reg_rdata}, {32'b0, m_read(int'(reg_addr))});
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic look(int a);
      @(posedge clk); #1; reg_addr = 3'(a);
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      idle(3); #1;
      // R1: reset state seen at the ports
      cur_req = "R1";
      chk("reset pd",   {4'b0, rail_pd},   64'h0);
      chk("reset stat", {4'b0, rail_stat}, 64'h0);
      for (int a = 0; a < 6; a++) begin
         reg_addr = 3'(a); #1;
         chk("reset reg", {32'b0, reg_rdata}, 64'h0);
      end
      rst_n = 1;
      idle(2);

      // R4: request held while sampling off; R3 enter code 2
      cur_req = "R4";
      wr(1, 32'd5);
      wr(2, {2'd2, 30'h3});
      look(3); idle(10);
      cur_req = "R5";                 // R5: pd then status 5 cycles later
      wr(0, 32'd1);
      look(2); idle(12);

      // R6: zero dwell acts as one
      cur_req = "R6";
      wr(1, 32'd0);
      wr(4, {2'd2, 30'h2000_0001});
      look(5); idle(6);

      // R3 and R8: leave on rail 0 only, rail 1 stays down
      cur_req = "R8";
      wr(1, 32'd3);
      wr(2, {2'd1, 30'h1});
      look(3); idle(8);

      // R11: reserved code does nothing
      cur_req = "R11";
      wr(2, {2'd3, 30'h3FFF_FFFF});
      look(2); idle(6);
      // R3: idle code with a mask does nothing
      cur_req = "R3";
      wr(4, {2'd0, 30'h3FFF_FFFF});
      look(5); idle(6);

      // R9: both banks in flight; R10: busy write dropped
      cur_req = "R9";
      wr(1, 32'd8);
      wr(2, {2'd2, 30'h0F0});
      wr(4, {2'd1, 30'h1});
      cur_req = "R10";
      wr(2, {2'd2, 30'h3FFF_0000});
      look(2); idle(14);
      look(4); idle(4);

      // R7: command cleared, mask kept
      cur_req = "R7";
      look(2); idle(2);

      // R4 again: sampling off, request waits, then fires
      cur_req = "R4";
      wr(0, 32'd0);
      wr(4, {2'd2, 30'h00F0_0000});
      look(5); idle(10);
      wr(0, 32'd1);
      idle(12);

      // R2: walk the whole map including unused addresses
      cur_req = "R2";
      for (int a = 0; a < 8; a++) begin
         look(a); idle(1);
      end
      idle(2);
      finish_run();
   end
endmodule